// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block merges eleven event sources into a single vectored interrupt request for a small 8-bit processor core. Three sources form the core group: an external pin edge, a change on an input port, and a timer-0 overflow. Their flags and enables share one control byte with a peripheral-group enable and the global enable. The other eight sources form the peripheral group: timer-1 overflow, ADC done, serial receive, serial transmit, comparator 0, comparator 1, EEPROM write done, and clock-monitor failure. This group keeps its flags in one byte and its enables in another.

Every source latches its flag whatever the masks say. A request is taken only on an instruction-boundary strobe while global enable is set. Taking it pulses a take/push output for one cycle, presents the fixed vector 0x0004, and clears global enable in hardware. Only the return strobe, or a software write, sets global enable again. Flags are cleared only by software writing 0.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Every source event sets its flag on the next clock edge, even when its own enable, the group enable or global enable is 0.
- R2: A flag clears only when software writes 0 to it. Taking an interrupt leaves all flags unchanged. If a source event and a write of 0 to the same flag arrive in the same cycle, the flag ends up set.
- R3: The request is the OR of (flag AND enable) over the core group, ORed with the peripheral-group enable (control bit 6) AND the OR of (flag AND enable) over the peripheral group.
- R4: Global enable (control bit 7) resets to 0. No interrupt is taken while it is 0, and none is taken except in a cycle where instrBoundary is 1.
- R5: When an interrupt is taken, takeIrq and pushReq are 1 for exactly one cycle, vector reads 0x0004 in that cycle (0 otherwise), and global enable reads 0.
- R6: A retStrobe pulse sets global enable. A flag that is still set and enabled then causes a second take on the next boundary.
- R7: If a write clears global enable in the same cycle that a take would occur, no take happens. The flag stays set and is taken after global enable returns to 1.
- R8: The external pin passes through a two-flop synchronizer and an edge detector. Option register (address 3) bit 7 selects rising (1) or falling (0). With instrBoundary held high and global enable set, takeIrq rises on the fourth clock edge after the pin changes.
- R9: The port-change flag sets while the synchronized port differs from the value latched on the last read of address 3 with regRd. That read returns the synchronized port value in its low bits.
- R10: Register map. Address 0 holds {gEn, perGrpEn, chgEn, extEn, tmrEn, chgFlag, extFlag, tmrFlag} from bit 7 down to bit 0. Address 1 holds the peripheral flags and address 2 the peripheral enables, with bits 0..7 = timer-1, ADC, receive, transmit, comparator 0, comparator 1, EEPROM write, clock fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Write data |
| regRd | input | 1 | Read strobe (latches port value at address 3) |
| regRdData | output | 8 | Read data for regAddr |
| extPin | input | 1 | Asynchronous external interrupt pin |
| portIn | input | 6 | Asynchronous port watched for change |
| tmr0Ovf | input | 1 | Timer-0 overflow pulse |
| perEvt | input | 8 | Peripheral event pulses, bit order as R10 |
| instrBoundary | input | 1 | Instruction-boundary strobe from the core |
| retStrobe | input | 1 | Return-from-interrupt strobe |
| takeIrq | output | 1 | Interrupt taken this cycle |
| pushReq | output | 1 | Request to push the return address |
| vector | output | 13 | Program-counter load value |

## Verification
A vector table crosses source type with mask state. It includes a core source enabled and masked, a peripheral source with the group enable on and off, a mismatched peripheral enable, and an all-enabled peripheral set with one event. These cases separate the two levels of the request equation and confirm that flags latch no matter the mask. Directed sequences then cover:
- the race between a write clearing global enable and a take,
- the immediate retake after return with a flag left set,
- an event colliding with a software clear,
- pin latency counted edge by edge and both edge polarities,
- port-change detection against the latched read value.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int CORE_N = 3;
  localparam int PER_N  = 8;
  localparam int VEC_W  = 13;
  localparam logic [VEC_W-1:0] VEC_ADDR = 13'h0004;

  // register addresses
  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_PFLAG  = 2'd1;
  localparam logic [1:0] A_PEN    = 2'd2;
  localparam logic [1:0] A_OPT    = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCore;
    logic wrPerFlag;
    logic wrPerEn;
    logic wrOpt;
    logic rdPort;
  } regStrb_t;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  logic              gEn,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portIn,
  input  logic              tmr0Ovf,
  input  logic [PER_N-1:0]  perEvt,
  output logic [7:0]        regRdData,
  output logic              reqAny
);
  localparam int PAD = 7 - PORT_W;

  logic [CORE_N-1:0] coreFlag, coreEn, coreEvt;
  logic [PER_N-1:0]  perFlag, perEn;
  logic              perGrpEn, edgeRise, extPrev, extS, extEdge, portChg;
  logic [PORT_W-1:0] portS, portLatch;

  vic_sync #(.W(PORT_W + 1)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({extPin, portIn}),
    .dout({extS, portS})
  );

  assign extEdge = edgeRise ? (extS & ~extPrev) : (~extS & extPrev);
  assign portChg = (portS != portLatch);
  assign coreEvt = {portChg, extEdge, tmr0Ovf};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPrev   <= 1'b0;
      portLatch <= '0;
      edgeRise  <= 1'b0;
      coreEn    <= '0;
      perGrpEn  <= 1'b0;
      perEn     <= '0;
    end else begin
      extPrev <= extS;
      if (strb.rdPort) portLatch <= portS;
      if (strb.wrOpt)  edgeRise  <= regWrData[7];
      if (strb.wrCore) begin
        coreEn   <= regWrData[5:3];
        perGrpEn <= regWrData[6];
      end
      if (strb.wrPerEn) perEn <= regWrData;
    end
  end

  // flags: software value (or hold) ORed with the event, so the event wins
  for (genvar i = 0; i < CORE_N; i++) begin : g_coreFlag
    always_ff @(posedge clk) begin
      if (!rstN) coreFlag[i] <= 1'b0;
      else coreFlag[i] <= (strb.wrCore ? regWrData[i] : coreFlag[i]) | coreEvt[i];
    end
  end

  for (genvar j = 0; j < PER_N; j++) begin : g_perFlag
    always_ff @(posedge clk) begin
      if (!rstN) perFlag[j] <= 1'b0;
      else perFlag[j] <= (strb.wrPerFlag ? regWrData[j] : perFlag[j]) | perEvt[j];
    end
  end

  assign reqAny = (|(coreFlag & coreEn)) | (perGrpEn & (|(perFlag & perEn)));

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdData = {gEn, perGrpEn, coreEn, coreFlag};
      A_PFLAG: regRdData = perFlag;
      A_PEN:   regRdData = perEn;
      default: regRdData = {edgeRise, {PAD{1'b0}}, portS};
    endcase
  end

  // R1: an event always lands in its flag
  a_r1_per_evt_latch: assert property (@(posedge clk) disable iff (!rstN)
    (perEvt != '0) |=> ((perFlag & $past(perEvt)) == $past(perEvt)));

  // R2: without a write, no flag drops
  a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPerFlag |=> ((perFlag & $past(perFlag)) == $past(perFlag)));

  // R9: port mismatch raises the change flag
  a_r9_port_chg: assert property (@(posedge clk) disable iff (!rstN)
    (portS != portLatch) |=> coreFlag[2]);
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       wrGen,
  input  logic       instrBoundary,
  input  logic       retStrobe,
  input  logic       reqAny,
  output regStrb_t   strb,
  output logic       gEn,
  output logic       takeIrq
);
  logic gEnKill, takeNow;

  always_comb begin
    strb.wrCore    = regWr && (regAddr == A_CTRL);
    strb.wrPerFlag = regWr && (regAddr == A_PFLAG);
    strb.wrPerEn   = regWr && (regAddr == A_PEN);
    strb.wrOpt     = regWr && (regAddr == A_OPT);
    strb.rdPort    = regRd && (regAddr == A_OPT);
  end

  assign gEnKill = strb.wrCore && !wrGen;
  assign takeNow = instrBoundary && gEn && reqAny && !gEnKill;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gEn     <= 1'b0;
      takeIrq <= 1'b0;
    end else begin
      takeIrq <= takeNow;
      if (takeNow)          gEn <= 1'b0;
      else if (retStrobe)   gEn <= 1'b1;
      else if (strb.wrCore) gEn <= wrGen;
    end
  end

  // R4: take only at a boundary with global enable set
  a_r4_take_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(takeIrq) |-> ($past(instrBoundary) && $past(gEn)));

  // R5: global enable is down while the take is presented
  a_r5_take_clears_gen: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> !gEn);

  // R5: take lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> !takeIrq);

  // R6: return re-arms global enable
  a_r6_ret_sets_gen: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !reqAny) |=> gEn);

  // R7: a write clearing global enable blocks the take
  a_r7_kill_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCore && !wrGen) |=> !takeIrq);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic [7:0]        regWrData,
  input  logic              regRd,
  output logic [7:0]        regRdData,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portIn,
  input  logic              tmr0Ovf,
  input  logic [PER_N-1:0]  perEvt,
  input  logic              instrBoundary,
  input  logic              retStrobe,
  output logic              takeIrq,
  output logic              pushReq,
  output logic [VEC_W-1:0]  vector
);
  regStrb_t strb;
  logic     gEn, reqAny;

  vic_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .regAddr      (regAddr),
    .regWr        (regWr),
    .regRd        (regRd),
    .wrGen        (regWrData[7]),
    .instrBoundary(instrBoundary),
    .retStrobe    (retStrobe),
    .reqAny       (reqAny),
    .strb         (strb),
    .gEn          (gEn),
    .takeIrq      (takeIrq)
  );

  vic_datapath #(.PORT_W(PORT_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .gEn      (gEn),
    .extPin   (extPin),
    .portIn   (portIn),
    .tmr0Ovf  (tmr0Ovf),
    .perEvt   (perEvt),
    .regRdData(regRdData),
    .reqAny   (reqAny)
  );

  assign pushReq = takeIrq;
  assign vector  = takeIrq ? VEC_ADDR : '0;
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        regRd = 1'b0;
  logic [7:0]  regRdData;
  logic        extPin = 1'b0;
  logic [5:0]  portIn = '0;
  logic        tmr0Ovf = 1'b0;
  logic [7:0]  perEvt = '0;
  logic        instrBoundary = 1'b0;
  logic        retStrobe = 1'b0;
  logic        takeIrq, pushReq;
  logic [12:0] vector;

  int  nRun = 0, nFail = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .regRdData(regRdData),
    .extPin(extPin), .portIn(portIn), .tmr0Ovf(tmr0Ovf), .perEvt(perEvt),
    .instrBoundary(instrBoundary), .retStrobe(retStrobe),
    .takeIrq(takeIrq), .pushReq(pushReq), .vector(vector)
  );

  // {ctrl (no gEn), perEn, perEvt, tmr0 event, expected take}
  localparam logic [25:0] VECS [8] = '{
    {8'h08, 8'h00, 8'h00, 1'b1, 1'b1},
    {8'h00, 8'h00, 8'h00, 1'b1, 1'b0},
    {8'h40, 8'h02, 8'h02, 1'b0, 1'b1},
    {8'h00, 8'h02, 8'h02, 1'b0, 1'b0},
    {8'h40, 8'h01, 8'h02, 1'b0, 1'b0},
    {8'h40, 8'hFF, 8'h80, 1'b0, 1'b1},
    {8'h48, 8'h00, 8'h10, 1'b0, 1'b0},
    {8'h08, 8'hFF, 8'h04, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired before the sequence ended");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] ctrl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4 / R10: reset state
    rd(0, d); check("R4 reset ctrl", d, 8'h00);
    rd(1, d); check("R10 reset per flags", d, 8'h00);
    check("R4 reset take", takeIrq, 1'b0);

    // table walk: R1, R3, R5
    for (int i = 0; i < 8; i++) begin
      logic [25:0] v;
      v = VECS[i];
      ctrl = v[25:18];
      wr(1, 8'h00); wr(0, ctrl); wr(2, v[17:10]);
      perEvt = v[9:2]; tmr0Ovf = v[1];
      @(negedge clk);
      perEvt = '0; tmr0Ovf = 1'b0;
      rd(1, d); check("R1 per flags latched", d, v[9:2]);
      rd(0, d); check("R1 tmr flag latched", d[0], v[1]);
      wr(0, ctrl | 8'h80 | {7'b0, v[1]});
      instrBoundary = 1'b1;
      @(negedge clk);
      instrBoundary = 1'b0;
      check("R3 request decision", takeIrq, v[0]);
      check("R5 push", pushReq, v[0]);
      check("R5 vector", vector, v[0] ? 13'h0004 : 13'h0000);
      if (v[0]) begin
        rd(0, d); check("R5 gEn cleared", d[7], 1'b0);
      end
      wr(0, 8'h00);
    end

    // R7: write clearing gEn races the take
    wr(0, 8'h08);
    tmr0Ovf = 1'b1; @(negedge clk); tmr0Ovf = 1'b0;
    wr(0, 8'h89);
    instrBoundary = 1'b1;
    regAddr = 0; regWrData = 8'h09; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    check("R7 no take on kill", takeIrq, 1'b0);
    rd(0, d); check("R7 flag kept", d[0], 1'b1);
    wr(0, 8'h89);
    @(negedge clk);
    check("R7 taken later", takeIrq, 1'b1);
    check("R5 push with take", pushReq, 1'b1);
    @(negedge clk);
    check("R5 single pulse", takeIrq, 1'b0);
    rd(0, d); check("R2 take keeps flag", d[0], 1'b1);
    check("R5 gEn low after take", d[7], 1'b0);

    // R6: return with flag still set -> immediate retake
    retStrobe = 1'b1; @(negedge clk); retStrobe = 1'b0;
    check("R6 not yet", takeIrq, 1'b0);
    @(negedge clk);
    check("R6 second take", takeIrq, 1'b1);
    instrBoundary = 1'b0;

    // R2: event and clear in same cycle
    regAddr = 0; regWrData = 8'h08; regWr = 1'b1; tmr0Ovf = 1'b1;
    @(negedge clk);
    regWr = 1'b0; tmr0Ovf = 1'b0;
    rd(0, d); check("R2 event wins over clear", d[0], 1'b1);
    wr(0, 8'h08);
    rd(0, d); check("R2 software clear", d[0], 1'b0);

    // R4: gEn 0 blocks take
    tmr0Ovf = 1'b1; @(negedge clk); tmr0Ovf = 1'b0;
    instrBoundary = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 gEn low blocks", takeIrq, 1'b0);
    instrBoundary = 1'b0;
    wr(0, 8'h00);

    // R8: pin latency and edge select
    wr(3, 8'h80);
    wr(0, 8'h90);
    instrBoundary = 1'b1;
    extPin = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check("R8 latency edge count", takeIrq, (k == 4));
    end
    instrBoundary = 1'b0;
    wr(0, 8'h10);
    extPin = 1'b0;
    repeat (4) @(negedge clk);
    rd(0, d); check("R8 falling ignored in rising mode", d[1], 1'b0);
    wr(3, 8'h00);
    extPin = 1'b1;
    repeat (4) @(negedge clk);
    rd(0, d); check("R8 rising ignored in falling mode", d[1], 1'b0);
    extPin = 1'b0;
    repeat (4) @(negedge clk);
    rd(0, d); check("R8 falling detected", d[1], 1'b1);
    wr(0, 8'h00);

    // R9: port change vs latched value
    wr(0, 8'h20);
    portIn = 6'h05;
    repeat (4) @(negedge clk);
    rd(0, d); check("R9 change flagged", d[2], 1'b1);
    regAddr = 3; regRd = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRd = 1'b0;
    check("R9 port readback", d[5:0], 6'h05);
    wr(0, 8'h20);
    repeat (3) @(negedge clk);
    rd(0, d); check("R9 no change after read", d[2], 1'b0);

    done = 1;
    report();
    $finish;
  end
endmodule